// File: doc/BRIEF.md
# PRBS Pattern Checker with Sticky Error Flag

This block checks a serial test stream for bit errors. Each cycle of the pattern clock it takes one bit, synchronises to the sequence it is given, and from then on compares every received bit with the bit it predicts. It runs on the same pattern clock as the matching pattern generator. It handles three maximal-length pseudo-random sequences and a 10-bit repeating user pattern. The incoming data can be complemented before checking, so the block also accepts an inverted stream.

Synchronisation works in two steps. First the prediction register is seeded from the received bits. Then the block needs an unbroken run of correct predictions before it declares sync. In user-pattern mode, the last ten bits must also match some rotation of the pattern. Once in sync, the prediction register runs on its own bits. One bad bit therefore gives exactly one error. A dense burst of errors drops the block back into acquisition. Errors are reported two ways: a live one-cycle pulse, and a sticky flag in a status register that a read clears.

Top module: `prbs_chk`

## Requirements
- R1: The control register at address 0x29 resets to 0 and reads back what was written. Bit 0 enables the checker. Bit 1 complements the received data. Bits [3:2] select the sequence: 00 follows x^7+x^6+1, 01 follows x^10+x^7+1, 10 follows x^23+x^18+1, and 11 is the user pattern.
- R2: For a pseudo-random mode, a correct stream satisfies b(n) = b(n-7)^b(n-6), b(n-10)^b(n-7) or b(n-23)^b(n-18), according to the mode. After an enabling write, in_sync rises within 30 bits for the 7-bit, 10-bit and user modes, and within 40 bits for the 23-bit mode.
- R3: With bit 1 set, a complemented stream synchronises. With bit 1 clear, a complemented 7-bit stream never synchronises.
- R4: The user pattern is sent bit 0 first and repeats every 10 bits. The checker synchronises whatever rotation the stream starts at.
- R5: err_live pulses high for one cycle in the cycle after each mismatched bit received while in sync. It stays 0 during acquisition and while the checker is disabled.
- R6: The status register at address 0x2F reads {2'b00, sticky, err_live}. A mismatch in sync sets sticky. Mismatches during acquisition never set it.
- R7: A read of 0x2F clears sticky at that clock edge. If a mismatch in sync arrives in the same cycle, sticky stays set.
- R8: Once in sync, a mismatch opens a window of 32 bits. If 4 mismatches fall inside that window, in_sync drops in the cycle after the fourth. Fewer mismatches, or mismatches in separate windows, leave sync held. After a drop the checker synchronises again.
- R9: Any write to 0x29 restarts acquisition, and in_sync is 0 in the next cycle. While disabled, in_sync and err_live stay 0 and sticky is not set.
- R10: In sync, a single corrupted bit produces exactly one err_live pulse. The surrounding correct bits produce none.
- R11: After reset, the control value, the status value, in_sync and err_live are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pattern clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Received serial bit |
| user_pat | input | 10 | Repeating user pattern, bit 0 sent first |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; clears sticky when addressing status |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for bus_addr (combinational) |
| in_sync | output | 1 | Checker is synchronised |
| err_live | output | 1 | One-cycle pulse per mismatched bit in sync |

## Verification
The bench feeds a complemented stream with inversion off. A checker that accepted a stream complementary to a valid one would wrongly report sync. It flips a single bit after sync. A self-synchronising predictor would then give three pulses, not one. It lines up a bit error with the status read in the same cycle. A design that gave the clear priority would lose that error. It also places three errors in one window, and three more after an earlier window has expired, and sync must survive both. Then it places four errors in one window, and sync must drop on the fourth, not before and not after.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int HIST_W = 23;   // longest polynomial
    localparam int UPAT_W = 10;   // user pattern length

    typedef enum logic [1:0] {
        PAT_P7   = 2'b00,
        PAT_P10  = 2'b01,
        PAT_P23  = 2'b10,
        PAT_USER = 2'b11
    } pat_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_VERIFY,
        ST_LOCK
    } sync_st_e;

    // field layout is the control register bit layout
    typedef struct packed {
        pat_sel_e pat;
        logic     inv;
        logic     en;
    } det_cfg_t;

    function automatic int seed_len(pat_sel_e p);
        case (p)
            PAT_P7:  return 7;
            PAT_P10: return 10;
            PAT_P23: return HIST_W;
            default: return UPAT_W;
        endcase
    endfunction

    // h[0] is the most recent bit
    function automatic logic predict(pat_sel_e p, logic [HIST_W-1:0] h);
        case (p)
            PAT_P7:  return h[6] ^ h[5];
            PAT_P10: return h[9] ^ h[6];
            PAT_P23: return h[22] ^ h[17];
            default: return h[UPAT_W-1];
        endcase
    endfunction

    // true when the newest UPAT_W history bits are a rotation of the pattern
    function automatic logic user_hit(logic [HIST_W-1:0] h, logic [UPAT_W-1:0] u);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < UPAT_W; k++) begin
            logic ok;
            ok = 1'b1;
            for (int j = 0; j < UPAT_W; j++) begin
                if (h[j] != u[(k - j + UPAT_W) % UPAT_W]) ok = 1'b0;
            end
            hit = hit | ok;
        end
        return hit;
    endfunction

endpackage

// File: rtl/prbs_chk_regs.sv
module prbs_chk_regs
    import prbs_chk_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [5:0]  CTRL_ADDR = 6'h29,
    parameter logic [5:0]  STAT_ADDR = 6'h2F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_wdata,
    output logic [3:0]        bus_rdata,
    input  logic              err_hit,
    input  logic              err_live,
    output det_cfg_t          cfg,
    output logic              restart,
    output logic              err_sticky
);

    logic ctrl_sel, stat_sel;

    assign ctrl_sel = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign stat_sel = (bus_addr == ADDR_W'(STAT_ADDR));
    assign restart  = bus_wr && ctrl_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            err_sticky <= 1'b0;
        end else begin
            if (restart) cfg <= det_cfg_t'(bus_wdata);
            if (err_hit)
                err_sticky <= 1'b1;        // a new error wins over the clear
            else if (bus_rd && stat_sel)
                err_sticky <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_sel)      bus_rdata = cfg;
        else if (stat_sel) bus_rdata = {2'b00, err_sticky, err_live};
    end

endmodule

// File: rtl/prbs_chk_sync.sv
module prbs_chk_sync
    import prbs_chk_pkg::*;
#(
    parameter int LOCK_RUN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  det_cfg_t          cfg,
    input  logic              restart,
    input  logic              ser_in,
    input  logic [UPAT_W-1:0] user_pat,
    input  logic              drop,
    output logic              in_sync,
    output logic              mis_hit
);

    localparam int CNT_W = $clog2(HIST_W + 1);

    sync_st_e          st;
    logic [HIST_W-1:0] hist;
    logic [CNT_W-1:0]  cnt;
    logic              rx, pred, miss;
    logic [HIST_W-1:0] hist_rx, hist_pr;
    logic              seed_full;

    assign rx      = ser_in ^ cfg.inv;
    assign pred    = predict(cfg.pat, hist);
    assign miss    = (rx != pred);
    assign hist_rx = {hist[HIST_W-2:0], rx};
    assign hist_pr = {hist[HIST_W-2:0], pred};
    assign seed_full = (int'(cnt) + 1 >= seed_len(cfg.pat));

    assign in_sync = (st == ST_LOCK);
    assign mis_hit = in_sync && miss;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            hist <= '0;
            cnt  <= '0;
        end else if (restart || !cfg.en) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    st  <= ST_SEED;
                    cnt <= '0;
                end
                ST_SEED: begin
                    hist <= hist_rx;
                    if (seed_full && (cfg.pat != PAT_USER || user_hit(hist_rx, user_pat))) begin
                        st  <= ST_VERIFY;
                        cnt <= '0;
                    end else if (!seed_full) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    hist <= hist_rx;
                    if (miss) begin
                        st  <= ST_SEED;
                        cnt <= '0;
                    end else if (cnt == CNT_W'(LOCK_RUN - 1)) begin
                        st  <= ST_LOCK;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    hist <= hist_pr;          // free-running after sync
                    if (drop) begin
                        st  <= ST_SEED;
                        cnt <= '0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/prbs_chk_loss.sv
module prbs_chk_loss #(
    parameter int LOSS_WIN = 32,
    parameter int LOSS_THR = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic mis_hit,
    output logic drop
);

    localparam int WIN_W = $clog2(LOSS_WIN);
    localparam int ERR_W = $clog2(LOSS_THR + 1);

    logic [WIN_W-1:0] win;
    logic [ERR_W-1:0] errs;
    logic             open;

    assign open = (errs != '0) && (win != '0);
    assign drop = mis_hit && open && (int'(errs) + 1 >= LOSS_THR);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            errs <= '0;
            win  <= '0;
        end else if (mis_hit) begin
            if (open) begin
                errs <= errs + 1'b1;
                win  <= win - 1'b1;
            end else begin
                errs <= ERR_W'(1);
                win  <= WIN_W'(LOSS_WIN - 1);
            end
        end else if (open) begin
            win <= win - 1'b1;
        end else begin
            errs <= '0;
        end
    end

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_chk_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter logic [5:0] CTRL_ADDR = 6'h29,
    parameter logic [5:0] STAT_ADDR = 6'h2F,
    parameter int         LOCK_RUN  = 16,
    parameter int         LOSS_WIN  = 32,
    parameter int         LOSS_THR  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic [UPAT_W-1:0] user_pat,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_wdata,
    output logic [3:0]        bus_rdata,
    output logic              in_sync,
    output logic              err_live
);

    det_cfg_t cfg_q;
    logic     restart, mis_hit, drop, err_sticky, cfg_en;

    assign cfg_en = cfg_q.en;

    prbs_chk_regs #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_hit(mis_hit), .err_live(err_live),
        .cfg(cfg_q), .restart(restart), .err_sticky(err_sticky)
    );

    prbs_chk_sync #(.LOCK_RUN(LOCK_RUN)) u_sync (
        .clk(clk), .rst(rst), .cfg(cfg_q), .restart(restart),
        .ser_in(ser_in), .user_pat(user_pat), .drop(drop),
        .in_sync(in_sync), .mis_hit(mis_hit)
    );

    prbs_chk_loss #(.LOSS_WIN(LOSS_WIN), .LOSS_THR(LOSS_THR)) u_loss (
        .clk(clk), .rst(rst), .active(in_sync), .mis_hit(mis_hit), .drop(drop)
    );

    always_ff @(posedge clk) begin
        if (rst) err_live <= 1'b0;
        else     err_live <= mis_hit;
    end

endmodule

// File: rtl/prbs_chk_sva.sv
module prbs_chk_sva #(
    parameter int         ADDR_W    = 6,
    parameter logic [5:0] CTRL_ADDR = 6'h29,
    parameter logic [5:0] STAT_ADDR = 6'h2F
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              cfg_en,
    input logic              in_sync,
    input logic              err_live,
    input logic              err_sticky
);

    logic stat_rd, ctrl_wr;
    assign stat_rd = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    AST_LIVE_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
        err_live |-> $past(in_sync)); // R5
    AST_STICKY_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
        err_live |-> err_sticky); // R6
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !stat_rd) |=> err_sticky); // R7
    AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(err_sticky) |-> $past(stat_rd)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (!in_sync && !err_live)); // R9
    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !in_sync); // R9
    AST_SYNC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(cfg_en)); // R2

endmodule

bind prbs_chk prbs_chk_sva #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_sva (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .cfg_en(cfg_en), .in_sync(in_sync), .err_live(err_live), .err_sticky(err_sticky)
);

// File: tb/tb_prbs_chk.sv
`timescale 1ns/1ps
module tb_prbs_chk;

    localparam logic [5:0] CTRL = 6'h29;
    localparam logic [5:0] STAT = 6'h2F;

    // {stream/checker mode[1:0], ctrl invert, stream complemented, expect sync, max bits[6:0]}
    localparam logic [11:0] VEC [0:7] = '{
        {2'd0, 1'b0, 1'b0, 1'b1, 7'd30},
        {2'd1, 1'b0, 1'b0, 1'b1, 7'd30},
        {2'd2, 1'b0, 1'b0, 1'b1, 7'd40},
        {2'd3, 1'b0, 1'b0, 1'b1, 7'd30},
        {2'd0, 1'b1, 1'b1, 1'b1, 7'd30},
        {2'd0, 1'b0, 1'b1, 1'b0, 7'd60},
        {2'd1, 1'b1, 1'b1, 1'b1, 7'd30},
        {2'd3, 1'b1, 1'b1, 1'b1, 7'd30}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_in = 1'b0;
    logic [9:0] user_pat = 10'b0011010111;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       in_sync, err_live;

    int checks = 0, fails = 0;
    logic [22:0] sh;
    int          uidx;
    logic [1:0]  s_mode;
    logic        s_inv;
    int          pulses;

    always #10 clk = ~clk;

    prbs_chk dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .user_pat(user_pat),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_sync(in_sync), .err_live(err_live)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic flip);
        logic nb;
        case (s_mode)
            2'd0:    nb = sh[6] ^ sh[5];
            2'd1:    nb = sh[9] ^ sh[6];
            2'd2:    nb = sh[22] ^ sh[17];
            default: nb = user_pat[uidx];
        endcase
        if (s_mode != 2'd3) sh = {sh[21:0], nb};
        else uidx = (uidx == 9) ? 0 : uidx + 1;
        ser_in = nb ^ s_inv ^ flip;
        @(posedge clk); #5;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        if (err_live) pulses++;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        bus_addr = CTRL; bus_wdata = v; bus_wr = 1'b1;
        send(1'b0);
    endtask

    task automatic rd_stat(input logic flip);
        bus_addr = STAT; bus_rd = 1'b1;
        send(flip);
    endtask

    task automatic peek(input logic [5:0] a, output logic [3:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic stream(input logic [1:0] m, input logic inv);
        s_mode = m; s_inv = inv; sh = 23'h2ACE1; uidx = 3;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [3:0] v;
        stream(2'd0, 1'b0);
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        @(posedge clk); #5;

        // R11 reset state
        peek(CTRL, v); chk(v == 4'h0, "R11 ctrl", v, 0);
        peek(STAT, v); chk(v == 4'h0, "R11 status", v, 0);
        chk(!in_sync && !err_live, "R11 outputs", {in_sync, err_live}, 0);

        // R1 readback, disabled
        wr_ctrl(4'b1110);
        peek(CTRL, v); chk(v == 4'he, "R1 ctrl readback", v, 14);
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            send(i[0]);
            if (in_sync) pulses += 100;
        end
        chk(pulses == 0, "R9 disabled stays quiet", pulses, 0);

        // table walk
        for (int n = 0; n < 8; n++) begin
            logic [1:0] m;
            logic       ci, si, ex;
            int         mx, lock_at;
            {m, ci, si, ex} = VEC[n][11:7];
            mx = int'(VEC[n][6:0]);
            stream(m, si);
            wr_ctrl({m, ci, 1'b1});
            pulses = 0; lock_at = 0;
            for (int i = 1; i <= mx + 20; i++) begin
                send(1'b0);
                if (in_sync && lock_at == 0) lock_at = i;
            end
            if (ex) chk(lock_at != 0 && lock_at <= mx,
                        (m == 2'd3) ? "R4 user rotation sync" : (ci ? "R3 inverted sync" : "R2 sync time"),
                        lock_at, mx);
            else    chk(lock_at == 0, "R3 complement without invert", lock_at, 0);
            chk(pulses == 0, "R5 no pulses in acquisition", pulses, 0);
            peek(STAT, v); chk(v == 4'h0, "R6 acquisition leaves sticky clear", v, 0);
            if (ex) begin
                send(1'b1);
                chk(err_live == 1'b1, "R5 pulse after bad bit", err_live, 1);
                pulses = 0;
                for (int i = 0; i < 20; i++) send(1'b0);
                chk(pulses == 0 && in_sync, "R10 single error single pulse", pulses, 0);
                peek(STAT, v); chk(v == 4'b0010, "R6 sticky set", v, 2);
                rd_stat(1'b0);
                peek(STAT, v); chk(v == 4'h0, "R7 read clears", v, 0);
            end
            wr_ctrl(4'h0);
        end

        // R8 loss of sync
        stream(2'd0, 1'b0);
        wr_ctrl(4'b0001);
        for (int i = 0; i < 30; i++) send(1'b0);
        chk(in_sync, "R8 pre sync", in_sync, 1);
        send(1'b1); send(1'b0); send(1'b1); send(1'b0); send(1'b1);
        chk(in_sync, "R8 three errors keep sync", in_sync, 1);
        for (int i = 0; i < 40; i++) send(1'b0);
        send(1'b1); send(1'b0); send(1'b1); send(1'b0); send(1'b1);
        chk(in_sync, "R8 separate windows keep sync", in_sync, 1);
        for (int i = 0; i < 40; i++) send(1'b0);
        send(1'b1); send(1'b0); send(1'b1); send(1'b0); send(1'b1); send(1'b0);
        chk(in_sync, "R8 three in window", in_sync, 1);
        send(1'b1);
        chk(!in_sync && err_live, "R8 fourth error drops sync", {in_sync, err_live}, 1);
        for (int i = 0; i < 30; i++) send(1'b0);
        chk(in_sync, "R8 resync after drop", in_sync, 1);

        // R7 error and read in the same cycle
        rd_stat(1'b0);
        peek(STAT, v); chk(v == 4'h0, "R7 cleared before race", v, 0);
        rd_stat(1'b1);
        peek(STAT, v); chk(v == 4'b0011, "R7 error wins over clear", v, 3);
        rd_stat(1'b0);
        peek(STAT, v); chk(v == 4'h0, "R7 later read clears", v, 0);

        // R9 restart and disable
        wr_ctrl(4'b0001);
        chk(!in_sync, "R9 write restarts", in_sync, 0);
        for (int i = 0; i < 30; i++) send(1'b0);
        chk(in_sync, "R9 resync after restart", in_sync, 1);
        wr_ctrl(4'b0000);
        chk(!in_sync, "R9 disable drops sync", in_sync, 0);
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            send(i[0]);
            if (in_sync) pulses += 100;
        end
        chk(pulses == 0, "R9 disabled no pulses", pulses, 0);
        peek(STAT, v); chk(v == 4'h0, "R9 disabled sticky clear", v, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule